// File: doc/BRIEF.md
# Outstanding Remote Request Tracker

This block sits beside the local memory bus of a requesting node and follows every access that a local processor has sent off to another node. When a processor presents an access that must be served remotely, the tracker claims a free entry and answers the bus with a retry. It also removes the processor from bus arbitration (masks it) and emits the outbound network request. The processor stays masked until the matching reply has been placed in the entry's data buffer. It is then unmasked, and when it repeats the access the buffered line is handed to it directly on the bus. The entry is freed by that hit.

Replies arrive on a network reply port that carries a two-bit kind: 0 is read data, 1 is exclusive (store) data with an acknowledgement count, 2 is a negative acknowledgement (NAK), and 3 is one invalidation acknowledgement. A separate input carries invalidation requests aimed at this node. A NAK, or a read reply that arrives after an invalidation has already hit the pending read, frees the entry without data, so the processor starts the access again as a new request. An entry that waits too long is dropped. The processors waiting on it receive a bus error, and the address is captured.

Top module: `rrt_tracker`

## Requirements
- R1: A request with no address match while an entry is free answers in the same cycle with busRetry=1, busMaskSet=1 and netReqValid=1 (netReqAddr/netReqExcl copying the request), and the requester's cpuMask bit is 1 from the next cycle on.
- R2: A read reply (repKind=0) for a pending read buffers repData and clears the waiters' cpuMask bits after that edge. A request from a waiter for that address then gets busHit=1, busRetry=0 and busData equal to the buffered data, and frees the entry, so a later request for the address allocates anew.
- R3: A NAK reply (repKind=2) frees the matching entry and clears its waiters' cpuMask bits, and the next request for the address issues a new network request.
- R4: An invalidation (invValid) matching a pending read marks it stale. A later read reply for it acts as a NAK: the mask clears, no data is kept (no busHit), and the next request allocates anew.
- R5: A store entry is released only when its exclusive reply (repKind=1) has arrived and the acknowledgement counter, loaded with repAckCnt and decremented by each repKind=3, is zero. Acknowledgements may precede the reply (the counter goes negative, in two's complement). Release shows in cpuMask one cycle after the last event.
- R6: A request whose address matches a pending entry creates no entry (netReqValid=0), answers busRetry=1 and busMaskSet=1, and adds the requester to that entry's waiters.
- R7: With every entry in use and no address match, a request gets busRetry=1, busMaskSet=0 and netReqValid=0.
- R8: An entry still pending TIMEOUT cycles after allocation is freed. busErrValid pulses for one cycle with busErrCpus set to its waiters, their cpuMask bits clear, and errCapValid=1 with errCapAddr equal to the address.
- R9: After reset cpuMask is 0, busErrValid is 0 and errCapValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReqValid | input | 1 | Remote-needing access on the bus this cycle |
| busReqCpu | input | CPU_W | Requesting processor |
| busReqAddr | input | ADDR_W | Block address |
| busReqExcl | input | 1 | 1 for store (exclusive) access |
| busRetry | output | 1 | Tell requester to retry |
| busMaskSet | output | 1 | Requester is masked from arbitration |
| busHit | output | 1 | Buffered data supplied this cycle |
| busData | output | DATA_W | Supplied data |
| cpuMask | output | NCPU | Processors currently masked |
| netReqValid | output | 1 | Outbound network request |
| netReqAddr | output | ADDR_W | Outbound request address |
| netReqExcl | output | 1 | Outbound request is exclusive |
| repValid | input | 1 | Network reply valid |
| repKind | input | 2 | 0 read, 1 exclusive, 2 NAK, 3 inval ack |
| repAddr | input | ADDR_W | Reply address |
| repAckCnt | input | ACK_W | Acks to expect (exclusive reply) |
| repData | input | DATA_W | Reply data |
| invValid | input | 1 | Invalidation request valid |
| invAddr | input | ADDR_W | Invalidation address |
| busErrValid | output | 1 | One-cycle bus error pulse |
| busErrCpus | output | NCPU | Processors receiving the bus error |
| errCapValid | output | 1 | Error capture holds a cause |
| errCapAddr | output | ADDR_W | Address of last timed-out request |

## Verification
A corrupted entry state shows first in cpuMask: a processor that stays masked after its reply, or is unmasked early on a store with acknowledgements still due, differs in the cycle after the reply or acknowledgement edge. A lost or wrong buffer shows in busHit and busData on the processor's next request, and a freed-too-early entry shows as an unexpected netReqValid. A broken timer is seen as a missing or early busErrValid pulse within TIMEOUT cycles of allocation.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  typedef enum logic [1:0] {ST_FREE, ST_PEND, ST_STALE, ST_READY} entState_t;
  localparam logic [1:0] RK_READ = 2'd0;
  localparam logic [1:0] RK_EXCL = 2'd1;
  localparam logic [1:0] RK_NAK  = 2'd2;
  localparam logic [1:0] RK_ACK  = 2'd3;
  typedef struct packed {
    logic alloc;
    logic fill;
    logic loadAck;
    logic decAck;
    logic addWaiter;
    logic clear;
  } entStrobe_t;
endpackage

// File: rtl/rrt_dpath.sv
module rrt_dpath import rrt_pkg::*; #(
  parameter int NENT = 4,
  parameter int NCPU = 8,
  parameter int CPU_W = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ACK_W = 4,
  parameter int TMR_W = 7
) (
  input  logic clk,
  input  logic rstN,
  input  entStrobe_t [NENT-1:0] strobe,
  input  logic [NENT-1:0] runTimer,
  input  logic [CPU_W-1:0] reqCpu,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic reqExcl,
  input  logic [ACK_W-1:0] ackCnt,
  input  logic [DATA_W-1:0] fillData,
  output logic [NENT-1:0][ADDR_W-1:0] entAddr,
  output logic [NENT-1:0][DATA_W-1:0] entData,
  output logic [NENT-1:0][NCPU-1:0] entWait,
  output logic [NENT-1:0][ACK_W-1:0] entCnt,
  output logic [NENT-1:0] entHasData,
  output logic [NENT-1:0] entExcl,
  output logic [NENT-1:0][TMR_W-1:0] entTimer
);
  logic [NCPU-1:0] reqBit;
  assign reqBit = NCPU'(1) << reqCpu;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entWait <= '0;
      entHasData <= '0;
      entCnt <= '0;
      entTimer <= '0;
      entAddr <= '0;
      entExcl <= '0;
      entData <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (strobe[i].clear) begin
          entWait[i] <= '0;
          entHasData[i] <= 1'b0;
          entCnt[i] <= '0;
          entTimer[i] <= '0;
        end else if (strobe[i].alloc) begin
          entAddr[i] <= reqAddr;
          entExcl[i] <= reqExcl;
          entWait[i] <= reqBit;
          entHasData[i] <= 1'b0;
          entCnt[i] <= '0;
          entTimer[i] <= '0;
        end else begin
          if (strobe[i].addWaiter) entWait[i] <= entWait[i] | reqBit;
          if (strobe[i].fill) begin
            entData[i] <= fillData;
            entHasData[i] <= 1'b1;
          end
          // two's complement count: early acks drive it below zero
          entCnt[i] <= entCnt[i] + (strobe[i].loadAck ? ackCnt : '0)
                       - (strobe[i].decAck ? ACK_W'(1) : '0);
          entTimer[i] <= runTimer[i] ? entTimer[i] + TMR_W'(1) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/rrt_ctrl.sv
module rrt_ctrl import rrt_pkg::*; #(
  parameter int NENT = 4,
  parameter int NCPU = 8,
  parameter int CPU_W = 3,
  parameter int ADDR_W = 16,
  parameter int ACK_W = 4,
  parameter int TIMEOUT = 64,
  parameter int TMR_W = 7,
  parameter int IDX_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReqValid,
  input  logic [CPU_W-1:0] busReqCpu,
  input  logic [ADDR_W-1:0] busReqAddr,
  input  logic busReqExcl,
  input  logic repValid,
  input  logic [1:0] repKind,
  input  logic [ADDR_W-1:0] repAddr,
  input  logic invValid,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic [NENT-1:0][ADDR_W-1:0] entAddr,
  input  logic [NENT-1:0][NCPU-1:0] entWait,
  input  logic [NENT-1:0][ACK_W-1:0] entCnt,
  input  logic [NENT-1:0] entHasData,
  input  logic [NENT-1:0] entExcl,
  input  logic [NENT-1:0][TMR_W-1:0] entTimer,
  output entStrobe_t [NENT-1:0] strobe,
  output logic [NENT-1:0] runTimer,
  output logic busRetry,
  output logic busMaskSet,
  output logic busHit,
  output logic [IDX_W-1:0] hitIdx,
  output logic netReqValid,
  output logic [ADDR_W-1:0] netReqAddr,
  output logic netReqExcl,
  output logic [NCPU-1:0] cpuMask,
  output logic busErrValid,
  output logic [NCPU-1:0] busErrCpus,
  output logic errCapValid,
  output logic [ADDR_W-1:0] errCapAddr
);
  entState_t st [NENT];
  entState_t stNext [NENT];
  logic [NENT-1:0] pend, repM, reqM, invM, hitV, joinV, toV;
  logic anyMatch, anyFree, allocOk, toAny;
  logic [IDX_W-1:0] freeIdx;
  logic [NCPU-1:0] toCpus;
  logic [ADDR_W-1:0] toAddr;

  always_comb begin
    anyMatch = 1'b0; anyFree = 1'b0; freeIdx = '0; hitIdx = '0;
    busHit = 1'b0; cpuMask = '0; toAny = 1'b0; toCpus = '0; toAddr = '0;
    for (int i = 0; i < NENT; i++) begin
      pend[i]  = (st[i] == ST_PEND) || (st[i] == ST_STALE);
      repM[i]  = repValid && pend[i] && (entAddr[i] == repAddr);
      invM[i]  = invValid && (st[i] == ST_PEND) && !entExcl[i] && (entAddr[i] == invAddr);
      reqM[i]  = busReqValid && (st[i] != ST_FREE) && (entAddr[i] == busReqAddr);
      hitV[i]  = reqM[i] && (st[i] == ST_READY) && entWait[i][busReqCpu];
      joinV[i] = reqM[i] && pend[i];
      toV[i]   = pend[i] && (entTimer[i] == TMR_W'(TIMEOUT - 1));
      if (reqM[i]) anyMatch = 1'b1;
      if (hitV[i]) begin busHit = 1'b1; hitIdx = IDX_W'(i); end
      if ((st[i] == ST_FREE) && !anyFree) begin anyFree = 1'b1; freeIdx = IDX_W'(i); end
      if (pend[i]) cpuMask = cpuMask | entWait[i];
      if (toV[i]) begin
        toCpus = toCpus | entWait[i];
        if (!toAny) toAddr = entAddr[i];
        toAny = 1'b1;
      end
    end
    allocOk = busReqValid && !anyMatch && anyFree;
    busRetry = busReqValid && !busHit;
    busMaskSet = allocOk || (|joinV);
    netReqValid = allocOk;
    netReqAddr = busReqAddr;
    netReqExcl = busReqExcl;
    for (int i = 0; i < NENT; i++) begin
      strobe[i].alloc     = allocOk && (freeIdx == IDX_W'(i));
      strobe[i].addWaiter = joinV[i];
      strobe[i].fill      = repM[i] && ((repKind == RK_READ && st[i] == ST_PEND) || repKind == RK_EXCL);
      strobe[i].loadAck   = repM[i] && (repKind == RK_EXCL);
      strobe[i].decAck    = repM[i] && (repKind == RK_ACK) && entExcl[i];
      strobe[i].clear     = hitV[i] || toV[i] ||
                            (repM[i] && (repKind == RK_NAK || (repKind == RK_READ && st[i] == ST_STALE)));
      runTimer[i] = pend[i];
      stNext[i] = st[i];
      if (strobe[i].clear) stNext[i] = ST_FREE;
      else if (strobe[i].alloc) stNext[i] = ST_PEND;
      else if (strobe[i].fill && !entExcl[i]) stNext[i] = ST_READY;
      else if (invM[i]) stNext[i] = ST_STALE;
      else if (st[i] == ST_PEND && entExcl[i] && entHasData[i] && entCnt[i] == '0) stNext[i] = ST_READY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NENT; i++) st[i] <= ST_FREE;
      busErrValid <= 1'b0;
      busErrCpus <= '0;
      errCapValid <= 1'b0;
      errCapAddr <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) st[i] <= stNext[i];
      busErrValid <= toAny;
      busErrCpus <= toCpus;
      if (toAny) begin
        errCapValid <= 1'b1;
        errCapAddr <= toAddr;
      end
    end
  end
endmodule

// File: rtl/rrt_tracker.sv
module rrt_tracker import rrt_pkg::*; #(
  parameter int NENT = 4,
  parameter int NCPU = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ACK_W = 4,
  parameter int TIMEOUT = 64,
  localparam int CPU_W = $clog2(NCPU),
  localparam int IDX_W = $clog2(NENT),
  localparam int TMR_W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReqValid,
  input  logic [CPU_W-1:0] busReqCpu,
  input  logic [ADDR_W-1:0] busReqAddr,
  input  logic busReqExcl,
  output logic busRetry,
  output logic busMaskSet,
  output logic busHit,
  output logic [DATA_W-1:0] busData,
  output logic [NCPU-1:0] cpuMask,
  output logic netReqValid,
  output logic [ADDR_W-1:0] netReqAddr,
  output logic netReqExcl,
  input  logic repValid,
  input  logic [1:0] repKind,
  input  logic [ADDR_W-1:0] repAddr,
  input  logic [ACK_W-1:0] repAckCnt,
  input  logic [DATA_W-1:0] repData,
  input  logic invValid,
  input  logic [ADDR_W-1:0] invAddr,
  output logic busErrValid,
  output logic [NCPU-1:0] busErrCpus,
  output logic errCapValid,
  output logic [ADDR_W-1:0] errCapAddr
);
  entStrobe_t [NENT-1:0] strobe;
  logic [NENT-1:0] runTimer;
  logic [NENT-1:0][ADDR_W-1:0] entAddr;
  logic [NENT-1:0][DATA_W-1:0] entData;
  logic [NENT-1:0][NCPU-1:0] entWait;
  logic [NENT-1:0][ACK_W-1:0] entCnt;
  logic [NENT-1:0] entHasData, entExcl;
  logic [NENT-1:0][TMR_W-1:0] entTimer;
  logic [IDX_W-1:0] hitIdx;

  rrt_ctrl #(.NENT(NENT), .NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .ACK_W(ACK_W),
             .TIMEOUT(TIMEOUT), .TMR_W(TMR_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReqValid(busReqValid), .busReqCpu(busReqCpu),
    .busReqAddr(busReqAddr), .busReqExcl(busReqExcl), .repValid(repValid),
    .repKind(repKind), .repAddr(repAddr), .invValid(invValid), .invAddr(invAddr),
    .entAddr(entAddr), .entWait(entWait), .entCnt(entCnt), .entHasData(entHasData),
    .entExcl(entExcl), .entTimer(entTimer), .strobe(strobe), .runTimer(runTimer),
    .busRetry(busRetry), .busMaskSet(busMaskSet), .busHit(busHit), .hitIdx(hitIdx),
    .netReqValid(netReqValid), .netReqAddr(netReqAddr), .netReqExcl(netReqExcl),
    .cpuMask(cpuMask), .busErrValid(busErrValid), .busErrCpus(busErrCpus),
    .errCapValid(errCapValid), .errCapAddr(errCapAddr));

  rrt_dpath #(.NENT(NENT), .NCPU(NCPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .ACK_W(ACK_W), .TMR_W(TMR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .runTimer(runTimer), .reqCpu(busReqCpu),
    .reqAddr(busReqAddr), .reqExcl(busReqExcl), .ackCnt(repAckCnt), .fillData(repData),
    .entAddr(entAddr), .entData(entData), .entWait(entWait), .entCnt(entCnt),
    .entHasData(entHasData), .entExcl(entExcl), .entTimer(entTimer));

  assign busData = busHit ? entData[hitIdx] : '0;
endmodule

// File: rtl/rrt_chk.sv
module rrt_chk #(
  parameter int NCPU = 8,
  parameter int CPU_W = 3
) (
  input logic clk,
  input logic rstN,
  input logic busReqValid,
  input logic [CPU_W-1:0] busReqCpu,
  input logic busRetry,
  input logic busMaskSet,
  input logic busHit,
  input logic [NCPU-1:0] cpuMask,
  input logic netReqValid,
  input logic busErrValid,
  input logic [NCPU-1:0] busErrCpus
);
  a_r1_alloc_masks: assert property (@(posedge clk) disable iff (!rstN)
    netReqValid |-> (busRetry && busMaskSet));
  a_r1_mask_next: assert property (@(posedge clk) disable iff (!rstN)
    netReqValid |=> cpuMask[$past(busReqCpu)]);
  a_r2_hit_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    busHit |-> (busReqValid && !cpuMask[busReqCpu] && !netReqValid));
  a_r7_nomask_noreq: assert property (@(posedge clk) disable iff (!rstN)
    (busRetry && !busMaskSet) |-> !netReqValid);
  a_r8_err_has_cpu: assert property (@(posedge clk) disable iff (!rstN)
    busErrValid |-> (busErrCpus != '0 && (busErrCpus & cpuMask) == '0));
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busErrValid |=> !busErrValid);
endmodule

bind rrt_tracker rrt_chk #(.NCPU(NCPU), .CPU_W(CPU_W)) chk_i (.*);

// File: tb/rrt_tracker_tb_top.sv
module rrt_tracker_tb_top;
  localparam int NCPU = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ACK_W = 4;
  localparam int TIMEOUT = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReqValid = 1'b0;
  logic [2:0] busReqCpu = '0;
  logic [ADDR_W-1:0] busReqAddr = '0;
  logic busReqExcl = 1'b0;
  logic busRetry, busMaskSet, busHit, netReqValid, netReqExcl;
  logic [DATA_W-1:0] busData;
  logic [NCPU-1:0] cpuMask, busErrCpus;
  logic [ADDR_W-1:0] netReqAddr, errCapAddr;
  logic repValid = 1'b0;
  logic [1:0] repKind = '0;
  logic [ADDR_W-1:0] repAddr = '0;
  logic [ACK_W-1:0] repAckCnt = '0;
  logic [DATA_W-1:0] repData = '0;
  logic invValid = 1'b0;
  logic [ADDR_W-1:0] invAddr = '0;
  logic busErrValid, errCapValid;

  int checks = 0;
  int errors = 0;
  logic sRetry, sMask, sHit, sNet;
  logic [DATA_W-1:0] sData;

  always #5 clk = ~clk;

  rrt_tracker #(.NCPU(NCPU), .TIMEOUT(TIMEOUT)) dut_i (.*);

  typedef struct packed {
    logic [2:0] cpu;
    logic [15:0] addr;
    logic excl;
    logic expRetry;
    logic expMask;
    logic expNet;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 16'h0100, 1'b0, 1'b1, 1'b1, 1'b1},  // R1
    '{3'd1, 16'h0200, 1'b0, 1'b1, 1'b1, 1'b1},  // R1
    '{3'd2, 16'h0300, 1'b1, 1'b1, 1'b1, 1'b1},  // R1 store
    '{3'd3, 16'h0400, 1'b0, 1'b1, 1'b1, 1'b1},  // R1
    '{3'd5, 16'h0500, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 full
    '{3'd4, 16'h0100, 1'b0, 1'b1, 1'b1, 1'b0}   // R6 join
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] cpu, input logic [15:0] addr, input logic excl);
    busReqValid = 1'b1; busReqCpu = cpu; busReqAddr = addr; busReqExcl = excl;
    #1;
    sRetry = busRetry; sMask = busMaskSet; sHit = busHit; sNet = netReqValid; sData = busData;
    @(negedge clk);
    busReqValid = 1'b0;
  endtask

  task automatic doRep(input logic [1:0] kind, input logic [15:0] addr,
                       input logic [ACK_W-1:0] cnt, input logic [DATA_W-1:0] data);
    repValid = 1'b1; repKind = kind; repAddr = addr; repAckCnt = cnt; repData = data;
    @(negedge clk);
    repValid = 1'b0;
  endtask

  task automatic doInv(input logic [15:0] addr);
    invValid = 1'b1; invAddr = addr;
    @(negedge clk);
    invValid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 cpuMask", 64'(cpuMask), 0);
    chk("R9 busErrValid", 64'(busErrValid), 0);
    chk("R9 errCapValid", 64'(errCapValid), 0);

    for (int v = 0; v < 6; v++) begin
      doReq(VECS[v].cpu, VECS[v].addr, VECS[v].excl);
      chk("R1/R6/R7 busRetry", 64'(sRetry), 64'(VECS[v].expRetry));
      chk("R1/R6/R7 busMaskSet", 64'(sMask), 64'(VECS[v].expMask));
      chk("R1/R6/R7 netReqValid", 64'(sNet), 64'(VECS[v].expNet));
    end
    chk("R1 R6 cpuMask after allocation", 64'(cpuMask), 64'h1F);

    // R2: read reply releases both waiters of 0x100
    doRep(2'd0, 16'h0100, '0, 32'hA5A5_0F0F);
    chk("R2 mask cleared", 64'(cpuMask), 64'h0E);
    doReq(3'd4, 16'h0100, 1'b0);
    chk("R2 busHit", 64'(sHit), 1);
    chk("R2 busRetry", 64'(sRetry), 0);
    chk("R2 busData", 64'(sData), 64'hA5A5_0F0F);
    doReq(3'd0, 16'h0100, 1'b0);
    chk("R2 freed entry reallocates", 64'(sNet), 1);

    // R3: NAK frees entry and unmasks
    doRep(2'd2, 16'h0100, '0, '0);
    chk("R3 cpu0 unmasked", 64'(cpuMask[0]), 0);
    doRep(2'd2, 16'h0200, '0, '0);
    chk("R3 cpu1 unmasked", 64'(cpuMask[1]), 0);
    doReq(3'd1, 16'h0200, 1'b0);
    chk("R3 reissue netReqValid", 64'(sNet), 1);

    // R4: invalidation overtakes read reply
    doInv(16'h0400);
    chk("R4 still masked while stale", 64'(cpuMask[3]), 1);
    doRep(2'd0, 16'h0400, '0, 32'hDEAD_BEEF);
    chk("R4 unmasked after late reply", 64'(cpuMask[3]), 0);
    doReq(3'd3, 16'h0400, 1'b0);
    chk("R4 no hit on stale data", 64'(sHit), 0);
    chk("R4 new request issued", 64'(sNet), 1);

    // R5: store with early ack, count 2
    doRep(2'd3, 16'h0300, '0, '0);
    doRep(2'd1, 16'h0300, 4'd2, 32'h1234_5678);
    @(negedge clk);
    chk("R5 masked with ack due", 64'(cpuMask[2]), 1);
    doRep(2'd3, 16'h0300, '0, '0);
    @(negedge clk);
    chk("R5 released at zero", 64'(cpuMask[2]), 0);
    doReq(3'd2, 16'h0300, 1'b1);
    chk("R5 store hit", 64'(sHit), 1);
    chk("R5 store data", 64'(sData), 64'h1234_5678);

    // R8: free 0x200, let 0x400 time out
    doRep(2'd2, 16'h0200, '0, '0);
    begin
      int waitCyc;
      waitCyc = 0;
      while (!busErrValid && waitCyc < TIMEOUT + 4) begin
        @(negedge clk);
        waitCyc++;
      end
      chk("R8 busErrValid within limit", 64'(busErrValid), 1);
    end
    chk("R8 busErrCpus", 64'(busErrCpus), 64'h08);
    chk("R8 mask cleared", 64'(cpuMask), 0);
    chk("R8 errCapValid", 64'(errCapValid), 1);
    chk("R8 errCapAddr", 64'(errCapAddr), 64'h0400);
    @(negedge clk);
    chk("R8 one-cycle pulse", 64'(busErrValid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule